// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A single timer channel behind a small word-wide register port. Software stores a reload value, selects a count width (16 or 32 bits), a tick divider (1, 16 or 256 clocks per tick) and one of three run modes (one-shot, periodic, free-running), then enables the channel. The counter steps down once per divided tick and, when it expires, sets a raw status flag and, if interrupts are enabled, a masked flag that drives a level interrupt output until software writes the clear register.

Two ways to change the reload value exist. Writing the primary reload register restarts an enabled count at once. Writing the deferred reload register only changes the value used at the next automatic reload, so a running period can be retimed without a glitch. Free-running mode ignores the stored value on expiry and wraps to the all-ones value of the selected width.

The bus port is a single-cycle valid/write/address/data interface; read data is combinational from the register state while a read is presented.

Top module: `dcnt_timer`

## Requirements
- R1: After reset the stored reload value reads 0xFFFFFFFF, the control register reads 0x20 (interrupt enable set, channel disabled), the current count reads 0, both status flags read 0 and `irqOut` is low.
- R2: The prescale field (control bits 3:2) selects one tick every 1 clock (value 0), 16 clocks (value 1) or 256 clocks (values 2 and 3); the tick divider restarts from zero whenever the count restarts.
- R3: With control bit 1 clear the counter uses only bits 15:0 of any value it loads (restart or reload); with bit 1 set it uses all 32 bits.
- R4: A write to offset 0x00 stores the reload value and, if the channel is enabled, loads the counter from the written value on the next clock; if disabled the counter is untouched.
- R5: A write to offset 0x18 changes only the stored reload value and leaves the running count alone; reads of offset 0x00 and 0x18 both return the stored reload value.
- R6: A control write that changes bit 7 (enable) from 0 to 1 loads the counter from the stored reload value; a control write with enable already 1 does not reload; writes to offset 0x04 have no effect.
- R7: On each tick a count above 1 decrements by one; a tick that finds the count at 1 or 0 is an expiry, so a loaded value N of at least 1 expires on the Nth tick and a loaded 0 expires on the first tick.
- R8: An expiry sets the raw flag (offset 0x10, bit 0) always, sets the masked flag (offset 0x14, bit 0) only if control bit 5 is 1, and `irqOut` equals the masked flag.
- R9: With control bit 0 set, an expiry leaves the count at 0 and stops further ticks and expiries until the next restart.
- R10: On expiry with bit 0 clear, bit 6 set reloads the stored reload value (periodic) and bit 6 clear reloads all ones of the selected width, 0xFFFFFFFF or 0xFFFF (free-running).
- R11: Any write to offset 0x0C clears both flags and drops `irqOut`; an expiry in the same clock wins and leaves the flags set.
- R12: While bit 7 is 0 the count and the tick divider hold their values.
- R13: Control reads back as {en, mode, irqEn, 0, prescale[1:0], size, oneShot} in bits 7:0 with upper bits zero; offsets 0x0C and 0x1C read zero; accesses whose two low address bits are nonzero are ignored and read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while a read is presented, zero otherwise |
| irqOut | output | 1 | Level interrupt, high while the masked flag is set |

## Verification
The bench chases the edges where a count is born or dies: loading 0 and 1, a reload-register write landing mid-count, a deferred write that must only show after the next expiry, re-enabling after a hold, and a clear landing on the same clock as an expiry. A design that counted N+1 ticks, restarted on a deferred write, let a masked flag rise with interrupts off, or let the clear beat the expiry would show a wrong count or interrupt level on a specific cycle. The 16-bit free-running wrap and the divide-by-256 setting reached through the reserved prescale code are run long enough to see whole periods.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
  localparam int CNT_W    = 32;
  localparam int HALF_W   = 16;
  localparam int PRE_STEP = 4;              // log2 of the divider step (16)
  localparam int PRE_W    = 2 * PRE_STEP;   // enough for divide-by-256
  localparam int IDX_W    = 3;

  typedef enum logic [IDX_W-1:0] {
    REG_RELOAD = 3'd0,
    REG_COUNT  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_ACK    = 3'd3,
    REG_RAW    = 3'd4,
    REG_MASKED = 3'd5,
    REG_DEFER  = 3'd6,
    REG_NONE   = 3'd7
  } regIdx_e;

  // strobes and configuration handed from control to datapath
  typedef struct packed {
    logic             restart;
    logic [CNT_W-1:0] restartVal;
    logic [CNT_W-1:0] reloadVal;
    logic             run;
    logic             oneShot;
    logic             periodic;
    logic             wide;
    logic [1:0]       prescale;
  } ctrlStrobe_t;
endpackage

// File: rtl/dcnt_datapath.sv
module dcnt_datapath
  import dcnt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [PRE_W-1:0] LIM_ONE  = '0;
  localparam logic [PRE_W-1:0] LIM_MID  = PRE_W'((1 << PRE_STEP) - 1);
  localparam logic [PRE_W-1:0] LIM_HIGH = '1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic             running;
  logic             tick;
  logic             atEnd;
  logic [CNT_W-1:0] wrapVal;
  logic [CNT_W-1:0] nextReload;

  always_comb begin
    unique case (strobe.prescale)
      2'd0:    preLimit = LIM_ONE;
      2'd1:    preLimit = LIM_MID;
      default: preLimit = LIM_HIGH;
    endcase
  end

  assign wrapVal    = strobe.wide ? '1 : CNT_W'({HALF_W{1'b1}});
  assign nextReload = strobe.periodic ? strobe.reloadVal : wrapVal;
  assign tick       = strobe.run && running && (preCnt >= preLimit);
  assign atEnd      = (count <= CNT_W'(1));
  assign expire     = tick && atEnd && !strobe.restart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      preCnt  <= '0;
      running <= 1'b0;
    end else if (strobe.restart) begin
      count   <= strobe.restartVal;
      preCnt  <= '0;
      running <= 1'b1;
    end else if (strobe.run && running) begin
      if (tick) begin
        preCnt <= '0;
        if (atEnd) begin
          if (strobe.oneShot) begin
            count   <= '0;
            running <= 1'b0;
          end else begin
            count <= nextReload;
          end
        end else begin
          count <= count - CNT_W'(1);
        end
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  p_hold_when_off_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.restart) |=> $stable(count));
  p_restart_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (count == $past(strobe.restartVal)));
  p_step_down_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !atEnd && !strobe.restart) |=> (count == $past(count) - CNT_W'(1)));
  p_oneshot_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (expire && strobe.oneShot) |=> (count == '0 && !expire));
endmodule

// File: rtl/dcnt_ctrl.sv
module dcnt_ctrl
  import dcnt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output ctrlStrobe_t       strobe,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irqOut
);
  localparam int BYTE_W = 2;
  localparam logic [CNT_W-1:0] HALF_MASK = CNT_W'({HALF_W{1'b1}});

  logic [CNT_W-1:0] reloadReg;
  logic             cfgOneShot, cfgWide, cfgIrqEn, cfgPeriodic, cfgEn;
  logic [1:0]       cfgPrescale;
  logic             rawFlag, maskFlag;

  logic             aligned;
  regIdx_e          idx;
  logic             wrAcc, rdAcc;
  logic [7:0]       ctrlView;

  assign aligned = (busAddr[BYTE_W-1:0] == '0);
  assign idx     = regIdx_e'(busAddr[BYTE_W +: IDX_W]);
  assign wrAcc   = busValid && busWrite && aligned;
  assign rdAcc   = busValid && !busWrite && aligned;

  assign ctrlView = {cfgEn, cfgPeriodic, cfgIrqEn, 1'b0, cfgPrescale, cfgWide, cfgOneShot};

  // restart strobe and value
  always_comb begin
    strobe.restart    = 1'b0;
    strobe.restartVal = '0;
    if (wrAcc && idx == REG_RELOAD && cfgEn) begin
      strobe.restart    = 1'b1;
      strobe.restartVal = cfgWide ? busWdata : (busWdata & HALF_MASK);
    end else if (wrAcc && idx == REG_CTRL && !cfgEn && busWdata[7]) begin
      strobe.restart    = 1'b1;
      strobe.restartVal = busWdata[1] ? reloadReg : (reloadReg & HALF_MASK);
    end
    strobe.reloadVal = cfgWide ? reloadReg : (reloadReg & HALF_MASK);
    strobe.run       = cfgEn;
    strobe.oneShot   = cfgOneShot;
    strobe.periodic  = cfgPeriodic;
    strobe.wide      = cfgWide;
    strobe.prescale  = cfgPrescale;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg   <= '1;
      cfgOneShot  <= 1'b0;
      cfgWide     <= 1'b0;
      cfgPrescale <= 2'd0;
      cfgIrqEn    <= 1'b1;
      cfgPeriodic <= 1'b0;
      cfgEn       <= 1'b0;
    end else if (wrAcc) begin
      unique case (idx)
        REG_RELOAD, REG_DEFER: reloadReg <= busWdata;
        REG_CTRL: begin
          cfgOneShot  <= busWdata[0];
          cfgWide     <= busWdata[1];
          cfgPrescale <= busWdata[3:2];
          cfgIrqEn    <= busWdata[5];
          cfgPeriodic <= busWdata[6];
          cfgEn       <= busWdata[7];
        end
        default: ;
      endcase
    end
  end

  // status flags: expiry has priority over the clear write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawFlag  <= 1'b0;
      maskFlag <= 1'b0;
    end else begin
      if (wrAcc && idx == REG_ACK) begin
        rawFlag  <= 1'b0;
        maskFlag <= 1'b0;
      end
      if (expire) begin
        rawFlag <= 1'b1;
        if (cfgIrqEn) maskFlag <= 1'b1;
      end
    end
  end

  assign irqOut = maskFlag;

  always_comb begin
    busRdata = '0;
    if (rdAcc) begin
      unique case (idx)
        REG_RELOAD, REG_DEFER: busRdata = reloadReg;
        REG_COUNT:             busRdata = count;
        REG_CTRL:              busRdata = CNT_W'(ctrlView);
        REG_RAW:               busRdata = CNT_W'(rawFlag);
        REG_MASKED:            busRdata = CNT_W'(maskFlag);
        default:               busRdata = '0;
      endcase
    end
  end

  p_raw_on_expire_r8: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> rawFlag);
  p_mask_needs_raw_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> rawFlag);
  p_mask_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!irqOut && !cfgIrqEn) |=> !irqOut);
  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && idx == REG_ACK && !expire) |=> (!rawFlag && !irqOut));
endmodule

// File: rtl/dcnt_timer.sv
module dcnt_timer
  import dcnt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut
);
  ctrlStrobe_t      strobe;
  logic [CNT_W-1:0] count;
  logic             expire;

  dcnt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .count    (count),
    .expire   (expire),
    .strobe   (strobe),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

  dcnt_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .count  (count),
    .expire (expire)
  );
endmodule

// File: tb/test_dcnt_timer.sv
module test_dcnt_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bV = 1'b0, bW = 1'b0;
  logic [4:0]  bA = '0;
  logic [31:0] bD = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  string curReq = "R1";

  dcnt_timer i_dcnt_timer (
    .clk(clk), .rstN(rstN), .busValid(bV), .busWrite(bW),
    .busAddr(bA), .busWdata(bD), .busRdata(rdata), .irqOut(irq)
  );

  always #10 clk = ~clk;   // 50 MHz

  // behavioural reference state
  logic [31:0] mLoad, mCount;
  int          mPre;
  bit          mRun, mEn, mMode, mIe, mSize, mOs, mRaw, mMask;
  logic [1:0]  mPs;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mLoad = 32'hFFFF_FFFF; mCount = 0; mPre = 0; mRun = 0;
      mEn = 0; mMode = 0; mIe = 1; mSize = 0; mOs = 0; mPs = 0;
      mRaw = 0; mMask = 0;
    end else begin
      bit wr, rs, tk, ex;
      int idx, lim;
      logic [31:0] rv;
      wr  = bV && bW && (bA[1:0] == 0);
      idx = bA[4:2];
      lim = (mPs == 0) ? 1 : (mPs == 1) ? 16 : 256;
      tk  = mEn && mRun && (mPre + 1 >= lim);
      rs = 0; rv = 0;
      if (wr && idx == 0 && mEn) begin rs = 1; rv = mSize ? bD : (bD & 32'hFFFF); end
      if (wr && idx == 2 && !mEn && bD[7]) begin rs = 1; rv = bD[1] ? mLoad : (mLoad & 32'hFFFF); end
      ex = tk && (mCount <= 1) && !rs;
      if (rs) begin mCount = rv; mPre = 0; mRun = 1; end
      else if (mEn && mRun) begin
        if (tk) begin
          mPre = 0;
          if (mCount <= 1) begin
            if (mOs) begin mCount = 0; mRun = 0; end
            else if (mMode) mCount = mSize ? mLoad : (mLoad & 32'hFFFF);
            else mCount = mSize ? 32'hFFFF_FFFF : 32'h0000_FFFF;
          end else mCount = mCount - 1;
        end else mPre++;
      end
      if (wr && idx == 3) begin mRaw = 0; mMask = 0; end
      if (ex) begin mRaw = 1; if (mIe) mMask = 1; end
      if (wr && (idx == 0 || idx == 6)) mLoad = bD;
      if (wr && idx == 2) begin
        mOs = bD[0]; mSize = bD[1]; mPs = bD[3:2]; mIe = bD[5]; mMode = bD[6]; mEn = bD[7];
      end
    end
  end

  function automatic logic [31:0] modelRead(logic [4:0] a);
    if (a[1:0] != 0) return 0;
    case (a[4:2])
      0, 6: return mLoad;
      1: return mCount;
      2: return {24'd0, mEn, mMode, mIe, 1'b0, mPs, mSize, mOs};
      4: return {31'd0, mRaw};
      5: return {31'd0, mMask};
      default: return 0;
    endcase
  endfunction

  // one bus cycle: drive after the falling edge, compare 1 ns later
  task automatic busCycle(bit v, bit w, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bV = v; bW = w; bA = a; bD = d;
    #1;
    vectors++;
    if (irq !== mMask) begin
      misses++;
      $display("FAIL %s irqOut actual=%0b expected=%0b t=%0t", curReq, irq, mMask, $time);
    end
    if (v && !w) begin
      logic [31:0] exp;
      exp = modelRead(a);
      vectors++;
      if (rdata !== exp) begin
        misses++;
        $display("FAIL %s read @%02h actual=%08h expected=%08h t=%0t", curReq, a, rdata, exp, $time);
      end
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d); busCycle(1, 1, a, d); endtask
  task automatic rd(logic [4:0] a); busCycle(1, 0, a, 0); endtask
  task automatic watch(int n, logic [4:0] a);
    for (int i = 0; i < n; i++) rd(a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    curReq = "R1";
    for (int k = 0; k < 8; k++) rd(5'(k * 4));
    // R13 control layout, undefined and misaligned accesses
    curReq = "R13";
    wr(5'h08, 32'hFFFF_FF7F); rd(5'h08);
    wr(5'h08, 32'h0000_0020); rd(5'h08);
    rd(5'h1C); rd(5'h0C); rd(5'h01); wr(5'h02, 32'h1234); rd(5'h00);
    // R4 load while disabled only stores
    curReq = "R4";
    wr(5'h00, 32'd5); rd(5'h04); rd(5'h00);
    // R6 enable edge restarts, R7 count to expiry, R8 irq
    curReq = "R6"; wr(5'h08, 32'hE2);
    curReq = "R7"; watch(8, 5'h04);
    curReq = "R8"; rd(5'h10); rd(5'h14);
    curReq = "R11"; wr(5'h0C, 0); rd(5'h10); rd(5'h14);
    // R4 load while running restarts
    curReq = "R4"; watch(2, 5'h04); wr(5'h00, 32'd3); watch(5, 5'h04);
    // R5 deferred reload
    curReq = "R5"; wr(5'h18, 32'd7); rd(5'h00); rd(5'h18);
    curReq = "R10"; watch(20, 5'h04);
    // R6 rewriting control while enabled: no restart; current writes ignored
    curReq = "R6"; wr(5'h08, 32'hE2); wr(5'h04, 32'h55); watch(4, 5'h04);
    // R12 hold when disabled, re-enable restarts
    curReq = "R12"; wr(5'h08, 32'h62); watch(6, 5'h04);
    curReq = "R6"; wr(5'h08, 32'hE2); watch(3, 5'h04);
    // R3 16-bit mode masking
    curReq = "R3"; wr(5'h08, 32'h60); wr(5'h00, 32'h1234_0004); wr(5'h08, 32'hE0);
    watch(6, 5'h04);
    // R10 free-running wrap to 0xFFFF in 16-bit mode
    curReq = "R10"; wr(5'h08, 32'h60); wr(5'h00, 32'd2); wr(5'h08, 32'hA0);
    watch(6, 5'h04); rd(5'h10);
    // R10 free-running 32-bit wrap
    wr(5'h08, 32'h22); wr(5'h00, 32'd1); wr(5'h08, 32'hA2); watch(4, 5'h04);
    // R2 divide by 16
    curReq = "R2"; wr(5'h08, 32'h62); wr(5'h0C, 0); wr(5'h00, 32'd2);
    wr(5'h08, 32'hE6); watch(40, 5'h04);
    // R2 divide by 256 via prescale code 3
    wr(5'h08, 32'h6E); wr(5'h00, 32'd2); wr(5'h08, 32'hEE); watch(530, 5'h04);
    // R9 one-shot
    curReq = "R9"; wr(5'h08, 32'h63); wr(5'h0C, 0); wr(5'h00, 32'd3);
    wr(5'h08, 32'hE3); watch(10, 5'h04); rd(5'h10); wr(5'h0C, 0); watch(5, 5'h10);
    // R8 interrupt disabled: raw only
    curReq = "R8"; wr(5'h08, 32'h42); wr(5'h00, 32'd2); wr(5'h08, 32'hC2);
    watch(4, 5'h10); rd(5'h14);
    // R11 clear coincides with expiry (count 1, divide by 1 => expiry every tick)
    curReq = "R11"; wr(5'h08, 32'h62); wr(5'h00, 32'd1); wr(5'h08, 32'hE2);
    wr(5'h0C, 0); rd(5'h10); rd(5'h14);
    // R7 load of zero expires on first tick
    curReq = "R7"; wr(5'h08, 32'h62); wr(5'h0C, 0); wr(5'h00, 32'd0);
    wr(5'h08, 32'hE3); rd(5'h10); rd(5'h04); watch(3, 5'h14);
    busCycle(0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    misses++;
    $display("FAIL watchdog expired actual=%0d expected<100000 cycles", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule